// File: doc/BRIEF.md
# Four-Channel Serial Interrupt Glue

This block is the register and interrupt glue that sits beside four serial channels: a keyboard link (channel 0), a sub-processor link (channel 1) and two RS-232C ports (channels 2 and 3). A host reaches it through a byte-wide, I/O-mapped port. Every channel has a baud-select byte and a control byte. The two RS-232C channels also have an interrupt mask byte and an interrupt status byte. The UARTs, the baud generators and the interrupt controllers are outside this block.

Each channel has a receive-ready and a transmit-ready input. Two control bits gate these onto one interrupt request per channel. The requests are routed onto fixed inputs of two downstream interrupt controllers. Bit 2 of a channel's status follows its request. Writes to the status register clear the bits that are set in the written byte. Each control write is also copied to the channel's UART as a loopback control byte, marked by a one-cycle strobe. The UART takes that strobe without back-pressure: there is no ready signal, so the byte is always delivered.

Top module: `sio_irq_glue`

## Requirements
- R1: Each channel has a baud byte and a control byte, both readable and writable. The baud/control address pairs are 0x0A/0x0B (ch0), 0x12/0x13 (ch1), 0x62/0x63 (ch2) and 0x72/0x73 (ch3). A write takes effect on the clock edge where `host_wr` is high. Reads are combinational.
- R2: The interrupt mask byte of ch2 is at 0x64 and that of ch3 is at 0x74. It is plain read/write storage. It has no effect on the request outputs.
- R3: The interrupt status of ch2 is at 0x65 and that of ch3 is at 0x75. A write clears every status bit that is 1 in the written byte and leaves the other bits unchanged.
- R4: Reads of 0x66 and 0x76 return 0xF0. A read of any other unmapped address returns 0xFF.
- R5: A channel's request is high exactly when (receive-ready AND control bit 6) OR (transmit-ready AND control bit 5).
- R6: Status bit 2 is loaded with the new request value on every control write and on every change of either ready input. A status clear in the same cycle is overridden by this load.
- R7: A control write raises the channel's `lb_valid` bit for exactly one cycle after the write edge. During that cycle the channel's `lb_ctrl` byte equals the written byte.
- R8: The requests of ch0, ch1 and ch2 drive bits 2, 3 and 4 of `irq_ctl0`. The request of ch3 drives bit 4 of `irq_ctl1`. All other bits of both outputs are 0.
- R9: After reset, all baud, control, mask and status bytes read 0, and every request output is low.
- R10: Only the low 16 address bits are decoded. Upper address bits are ignored.
- R11: The ready inputs are sampled at the clock edge. The request output reflects a change of a ready input, or a control write, from the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host I/O address; only the low 16 bits are decoded |
| host_wr | input | 1 | Write strobe, active for one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |
| rx_rdy | input | NCH | Receive-ready per channel |
| tx_rdy | input | NCH | Transmit-ready per channel |
| irq_ctl0 | output | 8 | Request inputs of the first interrupt controller |
| irq_ctl1 | output | 8 | Request inputs of the second interrupt controller |
| lb_ctrl | output | NCH*8 | Loopback control byte per channel, channel n at bits [8n+7:8n] |
| lb_valid | output | NCH | One-cycle strobe per channel: a new loopback byte is present |

## Verification
The assertions assume that the ready inputs are synchronous to `clk` and settle before each edge. They also assume that `host_wr` carries at most one write per cycle. The bench changes the ready inputs and the address/data only on the falling edge, and it issues writes as single-cycle pulses. The status and loopback checks rest on the rule that a control write and a status write to the same channel cannot occur in the same cycle. The bench's stimulus follows that rule. It does combine a ready change with a status clear so that the precedence stated in R6 is exercised.

// File: rtl/sio_glue_pkg.sv
package sio_glue_pkg;
  localparam int NCH       = 4;
  localparam int DEC_W     = 16;
  localparam int STAT_BIT  = 2;
  localparam int RX_EN_BIT = 6;
  localparam int TX_EN_BIT = 5;

  localparam logic [7:0] APPEND_VAL   = 8'hF0;
  localparam logic [7:0] UNMAPPED_VAL = 8'hFF;

  // per-channel baud address; control follows at +1, mask +2, status +3, append +4
  localparam logic [DEC_W-1:0] BAUD_ADDR [NCH] = '{16'h000A, 16'h0012, 16'h0062, 16'h0072};
  localparam bit               HAS_EXT   [NCH] = '{1'b0, 1'b0, 1'b1, 1'b1};
  // interrupt routing: controller select and input number
  localparam bit               IRQ_CTL   [NCH] = '{1'b0, 1'b0, 1'b0, 1'b1};
  localparam int               IRQ_PIN   [NCH] = '{2, 3, 4, 4};

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BAUD,
    SEL_CTRL,
    SEL_MASK,
    SEL_STAT,
    SEL_APPEND
  } reg_sel_e;
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
  import sio_glue_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic [1:0]        sel_ch,
  output logic [NCH-1:0]    wr_baud,
  output logic [NCH-1:0]    wr_ctrl,
  output logic [NCH-1:0]    wr_mask,
  output logic [NCH-1:0]    wr_stat
);
  logic [DEC_W-1:0] a16;
  assign a16 = addr[DEC_W-1:0];

  always_comb begin
    sel    = SEL_NONE;
    sel_ch = '0;
    for (int c = 0; c < NCH; c++) begin
      if (a16 == BAUD_ADDR[c]) begin
        sel = SEL_BAUD; sel_ch = 2'(c);
      end else if (a16 == BAUD_ADDR[c] + 16'd1) begin
        sel = SEL_CTRL; sel_ch = 2'(c);
      end else if (HAS_EXT[c] && a16 == BAUD_ADDR[c] + 16'd2) begin
        sel = SEL_MASK; sel_ch = 2'(c);
      end else if (HAS_EXT[c] && a16 == BAUD_ADDR[c] + 16'd3) begin
        sel = SEL_STAT; sel_ch = 2'(c);
      end else if (HAS_EXT[c] && a16 == BAUD_ADDR[c] + 16'd4) begin
        sel = SEL_APPEND; sel_ch = 2'(c);
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_strobe
    logic hit;
    assign hit        = wr && (sel_ch == 2'(c));
    assign wr_baud[c] = hit && (sel == SEL_BAUD);
    assign wr_ctrl[c] = hit && (sel == SEL_CTRL);
    assign wr_mask[c] = hit && (sel == SEL_MASK);
    assign wr_stat[c] = hit && (sel == SEL_STAT);
  end
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
  import sio_glue_pkg::*;
#(
  parameter bit EXT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_baud,
  input  logic       wr_ctrl,
  input  logic       wr_mask,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       rx_rdy,
  input  logic       tx_rdy,
  output logic [7:0] baud_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] mask_o,
  output logic [7:0] stat_o,
  output logic       irq_o,
  output logic       lb_valid_o
);
  logic [7:0] baud_q, ctrl_q, stat_q, ctrl_nxt, stat_nxt;
  logic       rx_q, tx_q, irq_q, lb_q, req_nxt, evt;

  assign ctrl_nxt = wr_ctrl ? wdata : ctrl_q;
  assign req_nxt  = (rx_rdy && ctrl_nxt[RX_EN_BIT]) || (tx_rdy && ctrl_nxt[TX_EN_BIT]);
  assign evt      = wr_ctrl || (rx_rdy != rx_q) || (tx_rdy != tx_q);

  always_comb begin
    stat_nxt = stat_q;
    if (wr_stat) stat_nxt = stat_q & ~wdata;
    if (evt)     stat_nxt[STAT_BIT] = req_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      irq_q  <= 1'b0;
      lb_q   <= 1'b0;
    end else begin
      if (wr_baud) baud_q <= wdata;
      ctrl_q <= ctrl_nxt;
      stat_q <= stat_nxt;
      rx_q   <= rx_rdy;
      tx_q   <= tx_rdy;
      irq_q  <= req_nxt;
      lb_q   <= wr_ctrl;
    end
  end

  if (EXT) begin : g_mask
    logic [7:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= wdata;
    end
    assign mask_o = mask_q;
  end else begin : g_nomask
    assign mask_o = '0;
  end

  assign baud_o     = baud_q;
  assign ctrl_o     = ctrl_q;
  assign stat_o     = stat_q;
  assign irq_o      = irq_q;
  assign lb_valid_o = lb_q;

  // R5: request follows the gated ready terms held in the sampled registers
  p_irq_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_q && ctrl_q[RX_EN_BIT]) || (tx_q && ctrl_q[TX_EN_BIT])) |-> irq_o);
  p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rx_q && ctrl_q[RX_EN_BIT]) && !(tx_q && ctrl_q[TX_EN_BIT])) |-> !irq_o);
  // R6: status bit 2 tracks request edges
  p_stat_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> stat_o[STAT_BIT]);
  p_stat_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> !stat_o[STAT_BIT]);
  // R7: loopback strobe carries the byte just written
  p_lb_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid_o |-> (ctrl_o == $past(wdata)));
  p_lb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid_o |=> (!lb_valid_o || $past(wr_ctrl)));
endmodule

// File: rtl/sio_irq_route.sv
module sio_irq_route
  import sio_glue_pkg::*;
(
  input  logic [NCH-1:0] req,
  output logic [7:0]     ctl0,
  output logic [7:0]     ctl1
);
  always_comb begin
    ctl0 = '0;
    ctl1 = '0;
    for (int c = 0; c < NCH; c++) begin
      if (IRQ_CTL[c]) ctl1[IRQ_PIN[c]] = ctl1[IRQ_PIN[c]] | req[c];
      else            ctl0[IRQ_PIN[c]] = ctl0[IRQ_PIN[c]] | req[c];
    end
  end

  // R8: bits outside the routed inputs stay idle
  always_comb begin
    a_unused_r8: assert ((ctl0 & 8'hE3) == 8'h00 && (ctl1 & 8'hEF) == 8'h00);
  end
endmodule

// File: rtl/sio_irq_glue.sv
module sio_irq_glue
  import sio_glue_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [NCH-1:0]    rx_rdy,
  input  logic [NCH-1:0]    tx_rdy,
  output logic [7:0]        irq_ctl0,
  output logic [7:0]        irq_ctl1,
  output logic [NCH*8-1:0]  lb_ctrl,
  output logic [NCH-1:0]    lb_valid
);
  reg_sel_e       sel;
  logic [1:0]     sel_ch;
  logic [NCH-1:0] wr_baud, wr_ctrl, wr_mask, wr_stat, req;
  logic [7:0]     baud [NCH];
  logic [7:0]     ctrl [NCH];
  logic [7:0]     mask [NCH];
  logic [7:0]     stat [NCH];

  sio_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr(host_addr), .wr(host_wr), .sel(sel), .sel_ch(sel_ch),
    .wr_baud(wr_baud), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask), .wr_stat(wr_stat)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_chan_regs #(.EXT(HAS_EXT[c])) i_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_baud(wr_baud[c]), .wr_ctrl(wr_ctrl[c]), .wr_mask(wr_mask[c]), .wr_stat(wr_stat[c]),
      .wdata(host_wdata), .rx_rdy(rx_rdy[c]), .tx_rdy(tx_rdy[c]),
      .baud_o(baud[c]), .ctrl_o(ctrl[c]), .mask_o(mask[c]), .stat_o(stat[c]),
      .irq_o(req[c]), .lb_valid_o(lb_valid[c])
    );
    assign lb_ctrl[8*c +: 8] = ctrl[c];
  end

  sio_irq_route i_route (.req(req), .ctl0(irq_ctl0), .ctl1(irq_ctl1));

  always_comb begin
    unique case (sel)
      SEL_BAUD:   host_rdata = baud[sel_ch];
      SEL_CTRL:   host_rdata = ctrl[sel_ch];
      SEL_MASK:   host_rdata = mask[sel_ch];
      SEL_STAT:   host_rdata = stat[sel_ch];
      SEL_APPEND: host_rdata = APPEND_VAL;
      default:    host_rdata = UNMAPPED_VAL;
    endcase
  end

  // R7: at most one loopback strobe per cycle, since writes are single
  p_lb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lb_valid));
  // R9: requests low in the first cycle after reset release
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_ctl0 == 8'h00 && irq_ctl1 == 8'h00));
endmodule

// File: tb/test_sio_irq_glue.sv
module test_sio_irq_glue;
  localparam int AW = 20;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic          host_wr = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata, irq_ctl0, irq_ctl1;
  logic [3:0]    rx_rdy = '0, tx_rdy = '0, lb_valid;
  logic [31:0]   lb_ctrl;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sio_irq_glue #(.ADDR_W(AW)) i_sio_irq_glue (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy),
    .irq_ctl0(irq_ctl0), .irq_ctl1(irq_ctl1), .lb_ctrl(lb_ctrl), .lb_valid(lb_valid)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #0.5 d = host_rdata;
  endtask

  task automatic expect_rd(string req, logic [AW-1:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic set_rdy(logic [3:0] rx, logic [3:0] tx);
    @(negedge clk);
    rx_rdy = rx; tx_rdy = tx;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int regs [10] = '{'h0A, 'h0B, 'h12, 'h13, 'h62, 'h63, 'h64, 'h65, 'h72, 'h75};
    foreach (regs[i]) expect_rd("R9 reset reg", AW'(regs[i]), 8'h00);
    chk("R9 irq_ctl0", irq_ctl0, 0);
    chk("R9 irq_ctl1", irq_ctl1, 0);
  endtask

  task automatic t_rw();
    int base [4] = '{'h0A, 'h12, 'h62, 'h72};
    for (int c = 0; c < 4; c++) begin
      wr(AW'(base[c]), 8'h11 * 8'(c + 1));
      wr(AW'(base[c] + 1), 8'h81 + 8'(c));
    end
    for (int c = 0; c < 4; c++) begin
      expect_rd("R1 baud", AW'(base[c]), 8'h11 * 8'(c + 1));
      expect_rd("R1 ctrl", AW'(base[c] + 1), 8'h81 + 8'(c));
    end
    wr(20'h3000A, 8'h5C);
    expect_rd("R10 upper bits ignored", 20'h0000A, 8'h5C);
    expect_rd("R10 aliased read", 20'hF0012, 8'h22);
    for (int c = 0; c < 4; c++) wr(AW'(base[c] + 1), 8'h00);
  endtask

  task automatic t_const();
    expect_rd("R4 append ch2", 20'h66, 8'hF0);
    expect_rd("R4 append ch3", 20'h76, 8'hF0);
    expect_rd("R4 unmapped 0x00", 20'h00, 8'hFF);
    expect_rd("R4 unmapped 0x0C", 20'h0C, 8'hFF);
    expect_rd("R4 unmapped 0x14", 20'h14, 8'hFF);
    expect_rd("R4 unmapped 0x67", 20'h67, 8'hFF);
    expect_rd("R4 no mask on ch0", 20'h0C, 8'hFF);
  endtask

  task automatic t_irq();
    wr(20'h0B, 8'h40);
    @(negedge clk); rx_rdy[0] = 1'b1;
    @(posedge clk); #0.5;
    chk("R11 rx sampled at edge", irq_ctl0, 8'h04);
    wr(20'h0B, 8'h20);
    chk("R5 rx gated off by bit6", irq_ctl0, 8'h00);
    set_rdy(4'b0001, 4'b0001);
    chk("R5 tx with bit5", irq_ctl0, 8'h04);
    wr(20'h0B, 8'h00);
    chk("R5 ctrl cleared", irq_ctl0, 8'h00);
    wr(20'h0B, 8'h9F);
    chk("R5 other ctrl bits no effect", irq_ctl0, 8'h00);
    wr(20'h0B, 8'h00);
    set_rdy(4'b0000, 4'b0000);
  endtask

  task automatic t_route();
    wr(20'h0B, 8'h40); wr(20'h13, 8'h40); wr(20'h63, 8'h40); wr(20'h73, 8'h40);
    set_rdy(4'b0010, 4'b0000);
    chk("R8 ch1 ctl0", irq_ctl0, 8'h08); chk("R8 ch1 ctl1", irq_ctl1, 8'h00);
    set_rdy(4'b0100, 4'b0000);
    chk("R8 ch2 ctl0", irq_ctl0, 8'h10); chk("R8 ch2 ctl1", irq_ctl1, 8'h00);
    set_rdy(4'b1000, 4'b0000);
    chk("R8 ch3 ctl0", irq_ctl0, 8'h00); chk("R8 ch3 ctl1", irq_ctl1, 8'h10);
    set_rdy(4'b0000, 4'b0000);
    wr(20'h0B, 8'h00); wr(20'h13, 8'h00); wr(20'h63, 8'h00); wr(20'h73, 8'h00);
  endtask

  task automatic t_mask();
    wr(20'h64, 8'hFF);
    wr(20'h74, 8'h3C);
    expect_rd("R2 mask ch2", 20'h64, 8'hFF);
    expect_rd("R2 mask ch3", 20'h74, 8'h3C);
    wr(20'h63, 8'h40);
    set_rdy(4'b0100, 4'b0000);
    chk("R2 mask ff no gating", irq_ctl0, 8'h10);
    wr(20'h64, 8'h00);
    chk("R2 mask 00 no change", irq_ctl0, 8'h10);
    set_rdy(4'b0000, 4'b0000);
    wr(20'h63, 8'h00);
  endtask

  task automatic t_status();
    wr(20'h73, 8'h60);
    expect_rd("R6 status idle", 20'h75, 8'h00);
    set_rdy(4'b0000, 4'b1000);
    chk("R5 ch3 tx", irq_ctl1, 8'h10);
    expect_rd("R6 status set", 20'h75, 8'h04);
    wr(20'h75, 8'hFB);
    expect_rd("R3 clear of other bits keeps bit2", 20'h75, 8'h04);
    wr(20'h75, 8'h04);
    expect_rd("R3 clear bit2", 20'h75, 8'h00);
    chk("R3 clear leaves request", irq_ctl1, 8'h10);
    set_rdy(4'b0000, 4'b0000);
    chk("R6 request dropped", irq_ctl1, 8'h00);
    expect_rd("R6 status follows drop", 20'h75, 8'h00);
    // ready change in the same cycle as a clear: reload wins
    @(negedge clk);
    host_addr = 20'h75; host_wdata = 8'h04; host_wr = 1'b1; rx_rdy[3] = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    expect_rd("R6 load beats clear", 20'h75, 8'h04);
    wr(20'h73, 8'h00);
    expect_rd("R6 ctrl write reloads", 20'h75, 8'h00);
    set_rdy(4'b0000, 4'b0000);
  endtask

  task automatic t_loop();
    wr(20'h13, 8'hA5);
    chk("R7 strobe", lb_valid, 4'b0010);
    chk("R7 byte", lb_ctrl[15:8], 8'hA5);
    @(negedge clk);
    chk("R7 one cycle", lb_valid, 4'b0000);
    wr(20'h12, 8'h77);
    chk("R7 baud write no strobe", lb_valid, 4'b0000);
    wr(20'h13, 8'h00);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_const();
    t_irq();
    t_route();
    t_mask();
    t_status();
    t_loop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule